// File: doc/BRIEF.md
# Prioritised 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and offers one request to the processor. The request carries a priority level and a vector number. Each source has a pending bit that tracks its input line, and a bit in a software force register. Each source also has a mask bit and an 8-bit priority level. A source takes part only once its level is nonzero, so the level register doubles as the enable. A combinational resolver picks the winner from the registered state. Registered outputs then carry the winner's level, and a vector equal to 64 plus its index, to the processor.

Software reaches the controller through a single-cycle synchronous register bus with a 256-byte window. The bus gives word access to the pending, mask and force registers, and byte access to the per-source levels. Two one-byte command offsets set or clear a single mask bit, or the whole mask at once. An acknowledge offset returns the vector currently presented. There is no control state machine: the only sequence is write, then state update, then output update.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask is all ones, and pending, force, enable and every level register are zero. `cpu_level` is 0, `cpu_vector` is 24, and offset 0xE0 reads 24.
- R2: The pending bits follow `irq_in` one clock later. Offset 0x00 reads pending bits 63..32 and offset 0x04 reads bits 31..0. Writes to 0x00 and 0x04 have no effect.
- R3: A write to 0x08 loads mask bits 63..32 and a write to 0x0C loads mask bits 31..0. Both words read back from the same offsets.
- R4: A write to 0x1C sets mask bit `wdata[5:0]`. If `wdata[6]` is 1, all 64 mask bits are set instead.
- R5: A write to 0x1D clears mask bit `wdata[5:0]`. If `wdata[6]` is 1, all 64 mask bits are cleared instead. Data bits above bit 6 are ignored.
- R6: A write to offset 0x40+n stores `wdata[7:0]` as the level of source n and reads back zero-extended. The source is enabled while that value is nonzero and disabled while it is zero.
- R7: A source is active when (pending OR forced) AND enabled AND NOT masked. Sources that are not active never win.
- R8: The winner is the active source with the greatest level. Among active sources with equal level, the highest index wins.
- R9: With a winner, `cpu_level` is its level and `cpu_vector` is 64 plus its index. With no active source, `cpu_level` is 0 and `cpu_vector` is 24.
- R10: Offset 0xE0 reads the current `cpu_vector`. Offsets 0xE1–0xE7 and every undecoded offset read 0, and writes to undecoded offsets change nothing.
- R11: `cpu_level` and `cpu_vector` change exactly one clock after the register state they depend on changes. `bus_rdata` is loaded at the clock edge that samples `bus_rd`.
- R12: A write to 0x10 loads force bits 63..32 and a write to 0x14 loads force bits 31..0. Both words read back from the same offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_level | output | 8 | Priority level presented to the processor (0 = none) |
| cpu_vector | output | 8 | Vector number presented to the processor |

## Verification
A register write takes effect at the edge that samples it. The resolved `cpu_level`/`cpu_vector` follow at the next edge. A change on `irq_in` reaches the outputs two edges later, because it first passes through the pending register. Read data is valid just after the edge that samples `bus_rd`. The scoreboard driver queues each expected item only in the cycle before the edge on which it becomes due. The monitor compares it shortly after that edge. One check deliberately samples the outputs at the write edge itself and expects the old values, which confirms the single-cycle lag.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    parameter int NUM_SRC  = 64;
    parameter int LVL_W    = 8;
    parameter int DATA_W   = 32;
    parameter int ADDR_W   = 8;
    parameter int VEC_W    = 8;
    parameter int VEC_BASE = 64;
    parameter int VEC_IDLE = 24;

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int HALF_W = NUM_SRC / 2;

    localparam logic [ADDR_W-1:0] OFF_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FRC_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FRC_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MSET    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_MCLR    = 8'h1D;
    localparam logic [ADDR_W-1:0] OFF_ACK     = 8'hE0;
    localparam logic [1:0]        LVL_PAGE    = 2'b01;

    typedef logic [NUM_SRC-1:0]            src_vec_t;
    typedef logic [NUM_SRC-1:0][LVL_W-1:0] lvl_arr_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_in,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output src_vec_t            pend_o,
    output src_vec_t            mask_o,
    output src_vec_t            force_o,
    output src_vec_t            en_o,
    output lvl_arr_t            lvl_o
);
    logic lvl_hit;
    assign lvl_hit = wr && (addr[7:6] == LVL_PAGE);

    // pending tracks the request lines; bus writes never touch it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= irq_in;
    end

    // mask: word loads plus single-bit and whole-mask commands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (wr) begin
            unique case (addr)
                OFF_MASK_HI: mask_o[NUM_SRC-1:HALF_W] <= wdata;
                OFF_MASK_LO: mask_o[HALF_W-1:0]       <= wdata;
                OFF_MSET: begin
                    if (wdata[6]) mask_o <= '1;
                    else          mask_o[wdata[IDX_W-1:0]] <= 1'b1;
                end
                OFF_MCLR: begin
                    if (wdata[6]) mask_o <= '0;
                    else          mask_o[wdata[IDX_W-1:0]] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // force word registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_o <= '0;
        end else if (wr) begin
            unique case (addr)
                OFF_FRC_HI: force_o[NUM_SRC-1:HALF_W] <= wdata;
                OFF_FRC_LO: force_o[HALF_W-1:0]       <= wdata;
                default: ;
            endcase
        end
    end

    // one level byte per source; enable follows nonzero level
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_o[g] <= '0;
                en_o[g]  <= 1'b0;
            end else if (lvl_hit && (addr[IDX_W-1:0] == IDX_W'(g))) begin
                lvl_o[g] <= wdata[LVL_W-1:0];
                en_o[g]  <= (wdata[LVL_W-1:0] != '0);
            end
        end
    end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_prio_pkg::*;
(
    input  src_vec_t            pend_i,
    input  src_vec_t            mask_i,
    input  src_vec_t            force_i,
    input  src_vec_t            en_i,
    input  lvl_arr_t            lvl_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [LVL_W-1:0]    lvl_o
);
    src_vec_t act;
    assign act = (pend_i | force_i) & en_i & ~mask_i;

    // ascending scan with >= hands equal levels to the higher index
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act[i] && (lvl_i[i] >= lvl_o)) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [63:0]         irq_in,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [7:0]          cpu_level,
    output logic [7:0]          cpu_vector
);
    src_vec_t           pend_q, mask_q, force_q, en_q;
    lvl_arr_t           lvl_q;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [DATA_W-1:0]  rd_mux;

    irq_prio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pend_o  (pend_q),
        .mask_o  (mask_q),
        .force_o (force_q),
        .en_o    (en_q),
        .lvl_o   (lvl_q)
    );

    irq_prio_resolve u_res (
        .pend_i  (pend_q),
        .mask_i  (mask_q),
        .force_i (force_q),
        .en_i    (en_q),
        .lvl_i   (lvl_q),
        .any_o   (win_any),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    // processor-facing outputs, one register stage after the resolver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= VEC_W'(VEC_IDLE);
        end else if (win_any) begin
            cpu_level  <= win_lvl;
            cpu_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end else begin
            cpu_level  <= '0;
            cpu_vector <= VEC_W'(VEC_IDLE);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr[7:6] == LVL_PAGE) begin
            rd_mux = DATA_W'(lvl_q[bus_addr[IDX_W-1:0]]);
        end else begin
            unique case (bus_addr)
                OFF_PEND_HI: rd_mux = pend_q[NUM_SRC-1:HALF_W];
                OFF_PEND_LO: rd_mux = pend_q[HALF_W-1:0];
                OFF_MASK_HI: rd_mux = mask_q[NUM_SRC-1:HALF_W];
                OFF_MASK_LO: rd_mux = mask_q[HALF_W-1:0];
                OFF_FRC_HI:  rd_mux = force_q[NUM_SRC-1:HALF_W];
                OFF_FRC_LO:  rd_mux = force_q[HALF_W-1:0];
                OFF_ACK:     rd_mux = DATA_W'(cpu_vector);
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] irq_in,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [7:0]  cpu_level,
    input logic [7:0]  cpu_vector,
    input logic [63:0] pend,
    input logic [63:0] mask,
    input logic [63:0] en
);
    AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == 8'd0) |-> (cpu_vector == 8'd24));   // R9

    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level != 8'd0) |-> (cpu_vector >= 8'd64 && cpu_vector < 8'd128));   // R9

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pend == $past(irq_in)));   // R2

    AST_MASK_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h1C && bus_wdata[6]) |=> (mask == {64{1'b1}}));   // R4

    AST_MASK_ALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h1D && bus_wdata[6]) |=> (mask == 64'd0));   // R5

    AST_LEVEL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:6] == 2'b01) |=>
        (en[$past(bus_addr[5:0])] == ($past(bus_wdata[7:0]) != 8'd0)));   // R6
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector),
    .pend       (pend_q),
    .mask       (mask_q),
    .en         (en_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cpu_level;
    logic [7:0]  cpu_vector;

    always #10 clk = ~clk;   // 50 MHz

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: compares every queued item just after the edge it is due on
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_out ? {16'd0, cpu_level, cpu_vector} : bus_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: %s actual=%h expected=%h", it.req,
                             it.is_out ? "level/vector" : "rdata", act, it.exp);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    // write and confirm outputs still show the old result at that edge
    task automatic wr_peek(input logic [7:0] a, input logic [31:0] d,
                           input logic [7:0] lv, input logic [7:0] vc, input string req);
        item_t it;
        wr(a, d);
        it.is_out = 1'b1; it.exp = {16'd0, lv, vc}; it.req = req;
        q.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        it.is_out = 1'b0; it.exp = e; it.req = req;
        q.push_back(it);
    endtask

    task automatic chk_out(input logic [7:0] lv, input logic [7:0] vc, input string req);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        it.is_out = 1'b1; it.exp = {16'd0, lv, vc}; it.req = req;
        q.push_back(it);
    endtask

    task automatic set_irq(input logic [63:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; irq_in = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h08, 32'hFFFF_FFFF, "R1");
        rd(8'h0C, 32'hFFFF_FFFF, "R1");
        rd(8'h00, 32'h0, "R1");
        rd(8'h14, 32'h0, "R1");
        rd(8'h40, 32'h0, "R1");
        rd(8'hE0, 32'd24, "R1");
        chk_out(8'd0, 8'd24, "R1");
        // R2 pending tracking and ignored writes
        set_irq((64'd1 << 40) | (64'd1 << 5));
        idle();
        rd(8'h00, 32'h0000_0100, "R2");
        rd(8'h04, 32'h0000_0020, "R2");
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_0020, "R2");
        rd(8'h00, 32'h0000_0100, "R2");
        chk_out(8'd0, 8'd24, "R7");
        // R7 level set but still masked
        wr(8'h45, 32'd3);
        chk_out(8'd0, 8'd24, "R7");
        rd(8'h45, 32'd3, "R6");
        // R5 clear single bit -> source 5 wins
        wr(8'h1D, 32'd5);
        rd(8'h0C, 32'hFFFF_FFDF, "R5");
        chk_out(8'd3, 8'd69, "R9");
        // R8 equal levels, higher index wins
        wr(8'h68, 32'd3);
        wr(8'h1D, 32'd40);
        rd(8'h08, 32'hFFFF_FEFF, "R5");
        chk_out(8'd3, 8'd104, "R8");
        // R8 greater level wins
        wr(8'h45, 32'd7);
        chk_out(8'd7, 8'd69, "R8");
        rd(8'hE0, 32'd69, "R10");
        // R4 set single bit and whole mask
        wr(8'h1C, 32'd5);
        chk_out(8'd3, 8'd104, "R4");
        wr(8'h1C, 32'h40);
        rd(8'h08, 32'hFFFF_FFFF, "R4");
        rd(8'h0C, 32'hFFFF_FFFF, "R4");
        chk_out(8'd0, 8'd24, "R4");
        // R5 clear whole mask
        wr(8'h1D, 32'h40);
        rd(8'h0C, 32'h0, "R5");
        rd(8'h08, 32'h0, "R5");
        chk_out(8'd7, 8'd69, "R5");
        // R6 zero level disables
        wr(8'h45, 32'd0);
        chk_out(8'd3, 8'd104, "R6");
        rd(8'h45, 32'd0, "R6");
        // R2 pending drops with the line (two edges to the outputs)
        set_irq(64'd0);
        chk_out(8'd0, 8'd24, "R2");
        // R12 force register drives sources
        wr(8'h14, 32'h0000_0004);
        wr(8'h42, 32'd9);
        rd(8'h14, 32'h0000_0004, "R12");
        chk_out(8'd9, 8'd66, "R12");
        wr(8'h10, 32'h8000_0000);
        wr(8'h7F, 32'd9);
        rd(8'h10, 32'h8000_0000, "R12");
        chk_out(8'd9, 8'd127, "R8");
        // R11 outputs lag a register write by one edge
        wr_peek(8'h7F, 32'd1, 8'd9, 8'd127, "R11");
        chk_out(8'd9, 8'd66, "R11");
        // R10 undecoded reads and writes
        rd(8'hE3, 32'h0, "R10");
        rd(8'hE7, 32'h0, "R10");
        rd(8'h20, 32'h0, "R10");
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'hE0, 32'h0000_00FF);
        rd(8'h0C, 32'h0, "R10");
        rd(8'h14, 32'h0000_0004, "R10");
        chk_out(8'd9, 8'd66, "R10");
        // R6 level readback zero-extended, only low byte kept
        wr(8'h7F, 32'hFFFF_FFAB);
        rd(8'h7F, 32'h0000_00AB, "R6");
        chk_out(8'hAB, 8'd127, "R6");
        // R3 mask word loads
        wr(8'h0C, 32'h0000_0004);
        wr(8'h08, 32'h8000_0000);
        rd(8'h0C, 32'h0000_0004, "R3");
        rd(8'h08, 32'h8000_0000, "R3");
        chk_out(8'd0, 8'd24, "R3");
        // R5 bits above 6 ignored in the clear command
        wr(8'h1D, 32'h0000_0082);
        rd(8'h0C, 32'h0, "R5");
        chk_out(8'd9, 8'd66, "R5");
        idle();
        idle();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule